// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the access address for a synchronous burst memory. When a burst starts, through either the processor-side strobe or the controller-side strobe, it captures the full external address. After that, only the two lowest address bits move, one step for each qualified advance. The higher bits keep the captured value until the next start.

A mode pin selects the stepping order. When it is high, the low bits are the start bits XORed with a 2-bit step count (interleaved order). When it is low, the low bits are the start bits plus the count, modulo 4 (linear order). The count is stored on its own, so the address is formed from the start bits, the count and the mode pin through combinational logic only.

A small control state machine has three states. `BST_IDLE` means no burst has started since reset. `BST_READ` is a read burst. `BST_WRITE` is a write burst. Its transitions are:
- `start_rd`: a load through the processor strobe, or through the controller strobe while the write qualifier is high, goes from any state to `BST_READ`.
- `start_wr`: a load through the controller strobe while the write qualifier is low goes from any state to `BST_WRITE`.
- `to_write`: a cycle that is not a load, with the write qualifier low, goes from `BST_READ` to `BST_WRITE`.
- Every other cycle stays in the current state.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the address output is all zeros and the sequencer is in `BST_IDLE`.
- R2: On any rising edge where `proc_strobe_n` or `ctrl_strobe_n` is low, the full external address is captured and the step count returns to 0. After that edge the output equals the captured address, whatever the advance input was on that edge.
- R3: With `ilv_mode` high (1), output bits [1:0] equal the start bits [1:0] XORed with the step count. For example, a start of 01 yields 01, 00, 11, 10.
- R4: With `ilv_mode` low (0), output bits [1:0] equal the start bits [1:0] plus the step count, modulo 4. For example, a start of 01 yields 01, 10, 11, 00.
- R5: Output bits above bit 1 hold the captured value on every edge that does not load.
- R6: The step count increments only on an edge where `adv_n` is low and both strobes are high. On any other edge that does not load, the address holds.
- R7: After the fourth address, a further advance wraps the count to 0, so the output returns to the start address.
- R8: In `BST_WRITE`, an advance additionally needs `wr_n` low (low means that byte-write data is present). With `wr_n` high, the address holds (write suspend). A load through `proc_strobe_n` always leads to `BST_READ`, whatever `wr_n` is.
- R9: In `BST_IDLE`, advances are ignored and the output stays at its reset value.
- R10: A change on `ilv_mode` alters the output in the same cycle, with no clock edge, because the count is stored separately from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_addr | input | ADDR_W | External start address |
| proc_strobe_n | input | 1 | Processor-side start strobe, active low; takes priority |
| ctrl_strobe_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_n | input | 1 | Write-advance qualifier, active low (byte write present) |
| ilv_mode | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_o | output | ADDR_W | Current access address |

## Verification
A wrong step count or wrong start bits show up on `addr_o` at the next sample after the faulty edge, because the output is registered state passed through combinational logic only. A wrong state in the controller is hidden until the next advance. An illegal step in `BST_IDLE`, or a missed write suspend, shows up one cycle after the advance that was wrongly taken. A mode mapping error shows up only at count values where XOR and addition give different results (counts 1 and 3 on odd starts), so the bench walks full bursts from odd start addresses in both modes.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        BST_IDLE  = 2'd0,
        BST_READ  = 2'd1,
        BST_WRITE = 2'd2
    } bst_state_e;

endpackage

// File: rtl/burst_seq_fsm.sv
module burst_seq_fsm
    import burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       proc_strobe_n,
    input  logic       ctrl_strobe_n,
    input  logic       adv_n,
    input  logic       wr_n,
    output logic       load_o,
    output logic       step_o,
    output bst_state_e state_o
);

    bst_state_e state_q;
    bst_state_e state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        load_o  = !proc_strobe_n || !ctrl_strobe_n;
        step_o  = 1'b0;
        state_d = state_q;
        if (load_o) begin
            // processor strobe starts a read regardless of the qualifier
            state_d = (!proc_strobe_n || wr_n) ? BST_READ : BST_WRITE;
        end else begin
            unique case (state_q)
                BST_IDLE: begin
                    state_d = BST_IDLE;
                end
                BST_READ: begin
                    step_o = !adv_n;
                    if (!wr_n) begin
                        state_d = BST_WRITE;
                    end
                end
                BST_WRITE: begin
                    step_o = !adv_n && !wr_n;
                end
                default: begin
                    state_d = BST_IDLE;
                end
            endcase
        end
    end

    assign state_o = state_q;

    // R9: idle persists while no strobe is seen
    a_r9_idle_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BST_IDLE && proc_strobe_n && ctrl_strobe_n) |=> (state_q == BST_IDLE));

    // R8: processor-strobe load always lands in read
    a_r8_proc_load_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n) |=> (state_q == BST_READ));

endmodule

// File: rtl/burst_step_cnt.sv
module burst_step_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] ext_i,
    output logic [ADDR_W-1:0] start_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_o <= '0;
        end else if (load_i) begin
            start_o <= ext_i;
        end
    end

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input  logic [ADDR_W-1:0] start_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              ilv_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [CNT_W-1:0] ilv_bits;
    logic [CNT_W-1:0] lin_bits;

    // interleaved order: one XOR lane per burst bit
    for (genvar i = 0; i < CNT_W; i++) begin : g_ilv_lane
        assign ilv_bits[i] = start_i[i] ^ cnt_i[i];
    end

    // linear order: modulo add within the burst field
    assign lin_bits = start_i[CNT_W-1:0] + cnt_i;

    assign addr_o = {start_i[ADDR_W-1:CNT_W], (ilv_i ? ilv_bits : lin_bits)};

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              adv_n,
    input  logic              wr_n,
    input  logic              ilv_mode,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int CNT_W = BURST_W;

    logic             load;
    logic             step;
    bst_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [ADDR_W-1:0] start;

    burst_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .proc_strobe_n(proc_strobe_n),
        .ctrl_strobe_n(ctrl_strobe_n),
        .adv_n        (adv_n),
        .wr_n         (wr_n),
        .load_o       (load),
        .step_o       (step),
        .state_o      (state)
    );

    burst_step_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(load),
        .step_i(step),
        .cnt_o (cnt)
    );

    burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .ext_i  (ext_addr),
        .start_o(start)
    );

    burst_addr_map #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_map (
        .start_i(start),
        .cnt_i  (cnt),
        .ilv_i  (ilv_mode),
        .addr_o (addr_o)
    );

    // R2: after a load edge the output equals the captured address
    a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strobe_n || !ctrl_strobe_n) |=> (addr_o == $past(ext_addr)));

    // R5: upper bits stay fixed across edges that do not load
    a_r5_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe_n && ctrl_strobe_n) |=> $stable(addr_o[ADDR_W-1:CNT_W]));

    // R6: no advance request means the count stays put
    a_r6_no_adv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe_n && ctrl_strobe_n && adv_n) |=> $stable(cnt));

    // R8: write suspend holds the count
    a_r8_write_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BST_WRITE && proc_strobe_n && ctrl_strobe_n && wr_n) |=> $stable(cnt));

endmodule

// File: tb/burst_addr_gen_bench.sv
`timescale 1ns/100ps
module burst_addr_gen_bench;

    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          proc_strobe_n = 1'b1;
    logic          ctrl_strobe_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          ilv_mode = 1'b1;
    logic [AW-1:0] addr_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // scoreboard queues
    logic [AW-1:0] exp_q[$];
    string         tag_q[$];

    // reference model state: 0 idle, 1 read, 2 write
    int            m_state = 0;
    logic [AW-1:0] m_start = '0;
    logic [1:0]    m_cnt = '0;

    burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_addr     (ext_addr),
        .proc_strobe_n(proc_strobe_n),
        .ctrl_strobe_n(ctrl_strobe_n),
        .adv_n        (adv_n),
        .wr_n         (wr_n),
        .ilv_mode     (ilv_mode),
        .addr_o       (addr_o)
    );

    always #2 clk = ~clk;

    function automatic logic [AW-1:0] model_addr(input logic ilv);
        logic [1:0] lo;
        lo = ilv ? (m_start[1:0] ^ m_cnt) : (m_start[1:0] + m_cnt);
        return {m_start[AW-1:2], lo};
    endfunction

    task automatic compare(input logic [AW-1:0] got, input logic [AW-1:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s addr_o=%h expected=%h", tag, got, exp);
        end
    endtask

    // driver: one clock cycle of stimulus, model update and expectation push
    task automatic cyc(input logic p_n, input logic c_n, input logic a_n, input logic w_n,
                       input logic ilv, input logic [AW-1:0] ea, input string tag);
        @(negedge clk);
        #1;
        proc_strobe_n = p_n;
        ctrl_strobe_n = c_n;
        adv_n         = a_n;
        wr_n          = w_n;
        ilv_mode      = ilv;
        ext_addr      = ea;
        if (!p_n || !c_n) begin
            m_start = ea;
            m_cnt   = 2'd0;
            m_state = (!p_n || w_n) ? 1 : 2;
        end else if (m_state == 1) begin
            if (!a_n) m_cnt = m_cnt + 2'd1;
            if (!w_n) m_state = 2;
        end else if (m_state == 2) begin
            if (!a_n && !w_n) m_cnt = m_cnt + 2'd1;
        end
        exp_q.push_back(model_addr(ilv));
        tag_q.push_back(tag);
    endtask

    // monitor: compare at the falling edge, before new stimulus
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [AW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compare(addr_o, e, t);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(addr_o, '0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare(addr_o, '0, "R1 after release");

        // R9: advances before any burst are ignored
        cyc(1, 1, 0, 1, 1, 17'h1ABCD, "R9 idle advance");
        cyc(1, 1, 0, 0, 1, 17'h1ABCD, "R9 idle advance write");
        cyc(1, 1, 0, 1, 0, 17'h0, "R9 idle advance linear");

        // R2 R3 R7: interleaved burst via processor strobe, adv low on load edge
        cyc(0, 1, 0, 1, 1, 17'h12345, "R2 proc load ignores adv");
        cyc(1, 1, 0, 1, 1, 17'h0, "R3 ilv step1 01->00");
        cyc(1, 1, 0, 1, 1, 17'h0, "R3 ilv step2 ->11");
        cyc(1, 1, 0, 1, 1, 17'h0, "R3 ilv step3 ->10");
        cyc(1, 1, 0, 1, 1, 17'h0, "R7 ilv wrap to start");

        // R6: hold with adv high, and R5 upper bits unchanged with ext_addr moving
        cyc(1, 1, 1, 1, 1, 17'h1FFFF, "R6 suspend read");
        cyc(1, 1, 1, 1, 1, 17'h00000, "R5 upper hold");

        // R2 R4 R7: linear burst via controller strobe
        cyc(1, 0, 1, 1, 0, 17'h0ABC5, "R2 ctrl load");
        cyc(1, 1, 0, 1, 0, 17'h0, "R4 lin step1 01->10");
        cyc(1, 1, 0, 1, 0, 17'h0, "R4 lin step2 ->11");
        cyc(1, 1, 0, 1, 0, 17'h0, "R4 lin step3 ->00");
        cyc(1, 1, 0, 1, 0, 17'h0, "R7 lin wrap");
        cyc(1, 1, 0, 1, 0, 17'h0, "R4 lin after wrap");

        // R10: mode change alters output without a clock edge
        @(negedge clk); #1;
        ilv_mode = 1'b1;
        #0.5;
        compare(addr_o, 17'h0ABC4, "R10 mode flip to ilv");
        ilv_mode = 1'b0;
        #0.5;
        compare(addr_o, 17'h0ABC6, "R10 mode flip to lin");

        // R6: advance with a strobe low is a load, not a step
        cyc(1, 0, 0, 1, 1, 17'h00007, "R6 strobe low blocks step");
        cyc(1, 1, 0, 1, 1, 17'h0, "R6 step after load");

        // R8: write burst through controller strobe with wr_n low
        cyc(1, 0, 1, 0, 0, 17'h10002, "R8 ctrl write load");
        cyc(1, 1, 0, 1, 0, 17'h0, "R8 write suspend no data");
        cyc(1, 1, 0, 0, 0, 17'h0, "R8 write step");
        cyc(1, 1, 0, 1, 0, 17'h0, "R8 write suspend again");
        cyc(1, 1, 0, 0, 0, 17'h0, "R8 write step2");
        cyc(1, 1, 1, 0, 0, 17'h0, "R6 write adv high hold");

        // R8: processor strobe with wr_n low still starts a read
        cyc(0, 0, 1, 0, 1, 17'h00011, "R8 proc load both strobes");
        cyc(1, 1, 0, 1, 1, 17'h0, "R8 read advances without wr");

        // R8: read burst turning into write
        cyc(1, 1, 0, 0, 1, 17'h0, "R8 read to write step");
        cyc(1, 1, 0, 1, 1, 17'h0, "R8 after to_write suspend");

        // R3: interleaved from start 11
        cyc(0, 1, 1, 1, 1, 17'h0F00F, "R2 load 11");
        cyc(1, 1, 0, 1, 1, 17'h0, "R3 ilv 11->10");
        cyc(1, 1, 0, 1, 1, 17'h0, "R3 ilv ->01");
        cyc(1, 1, 0, 1, 1, 17'h0, "R3 ilv ->00");

        // R1: reset mid-burst
        @(negedge clk); #1;
        rst_n = 1'b0;
        #0.5;
        compare(addr_o, '0, "R1 async reset");
        m_state = 0; m_start = '0; m_cnt = '0;
        @(negedge clk); #1;
        rst_n = 1'b1;
        cyc(1, 1, 0, 1, 1, 17'h0, "R9 idle after reset");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule